// File: doc/BRIEF.md
# Cascaded Interrupt Controller

This block gathers up to 92 interrupt request lines into two processor-facing outputs: a normal request line and a fast request line. It is built from three identical 32-source controller slices. Two of them act as subordinate slices that take external sources directly. The third is the main slice. Each subordinate slice drives its normal and fast outputs into four fixed inputs of the main slice. The main slice's remaining 28 inputs come from external sources. The main slice's two outputs are the block's outputs.

Every source in a slice has five control bits, each set through a simple word-wide register interface:
- an enable;
- a pending (status) bit that software clears by writing one;
- a sense-type bit that selects edge or level;
- a polarity bit;
- a routing bit that sends the source to the fast output instead of the normal one.

External sources pass through a two-flop synchroniser before detection. The cascade inputs of the main slice are already synchronous, so they skip the synchroniser. An interrupt handler acknowledges a source by first clearing its enable and then writing one to its pending bit.

Top module: `cic_top`

## Requirements
- R1: After reset, the main slice has enable = 0xC0000003, polarity = 0xC0000003, routing = 0xC0000000 and sense type = 0. All other registers of every slice, including all pending bits, are zero. Both outputs are low.
- R2: `irq_o` is high exactly when some source of the main slice is pending, enabled and routed normal. `fiq_o` is high exactly when some source of the main slice is pending, enabled and routed fast. A source with its enable bit at 0 affects neither output, but its pending bit still records requests.
- R3: For an edge-sensitive source, writing 1 to its pending bit clears that bit on the next clock. Writing 0 leaves it unchanged. A new edge in the same cycle as the clear wins.
- R4: With sense type 1 (edge), polarity 1 latches a pending bit on a rising edge and polarity 0 latches it on a falling edge. The opposite edge never sets the bit, and a latched bit stays set until it is cleared.
- R5: With sense type 0 (level), the pending bit equals the active level: the input itself when polarity is 1, its inverse when polarity is 0. While the level stays active, writing 1 to the pending bit has no effect.
- R6: A routing bit of 1 sends the source to the fast output of its slice. A routing bit of 0 sends it to the normal output.
- R7: Cascade wiring into the main slice:
  - subordinate slice A's normal output drives main input 0;
  - subordinate slice B's normal output drives main input 1;
  - A's fast output drives main input 30;
  - B's fast output drives main input 31.
  
  External main source `src_main[k]` drives main input k+2.
- R8: `unit` selects the slice: 0 is main, 1 is slice A, 2 is slice B, and 3 selects nothing, so writes are dropped and reads return 0. `addr` selects the register:
  - 0 is enable;
  - 1 is pending;
  - 2 is sense type;
  - 3 is polarity;
  - 4 is routing;
  - 5 is the read-only word pending AND enable;
  - 6 and 7 read as 0.
  
  `rdata` reflects the registers combinationally.
- R9: The acknowledge sequence (write 0 to a source's enable bit, then write 1 to its pending bit) drops the output that the source drove, and leaves the pending bit clear.
- R10: A change on an external source is driven after a clock edge. It appears in the pending bit after the third rising edge that follows, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| unit | input | 2 | Slice select |
| addr | input | 3 | Register select within the slice |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| src_main | input | 28 | External sources of main inputs 2..29 |
| src_sub_a | input | 32 | External sources of subordinate slice A |
| src_sub_b | input | 32 | External sources of subordinate slice B |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The properties assume that the write strobe lasts exactly one clock per access, and that unit and address are stable while it is high. The bench drives every bus access from a task that holds these signals from one falling edge to the next.

The properties also assume that the external sources may toggle at any time relative to the clock. The bench changes them only on falling edges and waits out the synchroniser before it judges pending state. The one exception is the latency scenario, which samples on both sides of the third edge.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;

    // register offsets inside one slice
    typedef enum logic [2:0] {
        REG_EN   = 3'd0,
        REG_ST   = 3'd1,
        REG_TYP  = 3'd2,
        REG_POL  = 3'd3,
        REG_RTE  = 3'd4,
        REG_PEND = 3'd5
    } reg_sel_e;

    // slice select codes
    typedef enum logic [1:0] {
        UNIT_MAIN = 2'd0,
        UNIT_SUBA = 2'd1,
        UNIT_SUBB = 2'd2
    } unit_sel_e;

endpackage

// File: rtl/cic_sync.sv
`timescale 1ns/1ps
module cic_sync #(
    parameter int unsigned  N      = 32,
    parameter logic [N-1:0] BYPASS = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (BYPASS[i]) begin : g_thru
            assign dout[i] = din[i];
        end else begin : g_two_ff
            logic meta_q;
            logic safe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    safe_q <= 1'b0;
                end else begin
                    meta_q <= din[i];
                    safe_q <= meta_q;
                end
            end
            assign dout[i] = safe_q;
        end
    end

endmodule

// File: rtl/cic_slice.sv
`timescale 1ns/1ps
module cic_slice
    import cic_pkg::*;
#(
    parameter int unsigned  N       = 32,
    parameter logic [N-1:0] EN_RST  = '0,
    parameter logic [N-1:0] POL_RST = '0,
    parameter logic [N-1:0] RTE_RST = '0,
    parameter logic [N-1:0] BYPASS  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic         wr,
    input  logic [2:0]   addr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rdata,
    output logic         irq,
    output logic         fiq
);

    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] st;
        logic [N-1:0] typ;
        logic [N-1:0] pol;
        logic [N-1:0] rte;
        logic [N-1:0] prev;
    } slice_t;

    slice_t       state_d, state_q;
    logic [N-1:0] src_s;
    logic [N-1:0] en_w, st_w, typ_w;
    logic [N-1:0] hit_edge, act_lvl, clr_mask, pend;

    cic_sync #(.N(N), .BYPASS(BYPASS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (src),
        .dout (src_s)
    );

    assign en_w  = state_q.en;
    assign st_w  = state_q.st;
    assign typ_w = state_q.typ;

    always_comb begin
        state_d  = state_q;
        // rising when polarity 1, falling when polarity 0
        hit_edge = (state_q.pol  & src_s & ~state_q.prev)
                 | (~state_q.pol & ~src_s & state_q.prev);
        act_lvl  = ~(src_s ^ state_q.pol);
        clr_mask = (wr && addr == REG_ST) ? wdata : '0;

        state_d.prev = src_s;
        state_d.st   = (typ_w & ((st_w & ~clr_mask) | hit_edge))
                     | (~typ_w & act_lvl);

        if (wr) begin
            case (addr)
                REG_EN:  state_d.en  = wdata;
                REG_TYP: state_d.typ = wdata;
                REG_POL: state_d.pol = wdata;
                REG_RTE: state_d.rte = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.en   <= EN_RST;
            state_q.pol  <= POL_RST;
            state_q.rte  <= RTE_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend = st_w & en_w;
    assign irq  = |(pend & ~state_q.rte);
    assign fiq  = |(pend & state_q.rte);

    always_comb begin
        case (addr)
            REG_EN:   rdata = en_w;
            REG_ST:   rdata = st_w;
            REG_TYP:  rdata = typ_w;
            REG_POL:  rdata = state_q.pol;
            REG_RTE:  rdata = state_q.rte;
            REG_PEND: rdata = pend;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/cic_top.sv
`timescale 1ns/1ps
module cic_top
    import cic_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   unit,
    input  logic [2:0]   addr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rdata,
    input  logic [N-5:0] src_main,
    input  logic [N-1:0] src_sub_a,
    input  logic [N-1:0] src_sub_b,
    output logic         irq_o,
    output logic         fiq_o
);

    localparam logic [N-1:0] CASC_IRQ = {{(N-2){1'b0}}, 2'b11};
    localparam logic [N-1:0] CASC_FIQ = {2'b11, {(N-2){1'b0}}};
    localparam logic [N-1:0] CASC_ALL = CASC_IRQ | CASC_FIQ;

    logic         irq_a, fiq_a, irq_b, fiq_b;
    logic [N-1:0] rd_main, rd_a, rd_b, main_src;

    assign main_src = {fiq_b, fiq_a, src_main, irq_b, irq_a};

    cic_slice #(.N(N)) u_sub_a (
        .clk(clk), .rst_n(rst_n), .src(src_sub_a),
        .wr(wr_en && unit == UNIT_SUBA), .addr(addr), .wdata(wdata),
        .rdata(rd_a), .irq(irq_a), .fiq(fiq_a)
    );

    cic_slice #(.N(N)) u_sub_b (
        .clk(clk), .rst_n(rst_n), .src(src_sub_b),
        .wr(wr_en && unit == UNIT_SUBB), .addr(addr), .wdata(wdata),
        .rdata(rd_b), .irq(irq_b), .fiq(fiq_b)
    );

    cic_slice #(
        .N(N), .EN_RST(CASC_ALL), .POL_RST(CASC_ALL),
        .RTE_RST(CASC_FIQ), .BYPASS(CASC_ALL)
    ) u_main (
        .clk(clk), .rst_n(rst_n), .src(main_src),
        .wr(wr_en && unit == UNIT_MAIN), .addr(addr), .wdata(wdata),
        .rdata(rd_main), .irq(irq_o), .fiq(fiq_o)
    );

    always_comb begin
        case (unit)
            UNIT_MAIN: rdata = rd_main;
            UNIT_SUBA: rdata = rd_a;
            UNIT_SUBB: rdata = rd_b;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/cic_checker.sv
`timescale 1ns/1ps
module cic_checker
    import cic_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr,
    input logic [2:0]   addr,
    input logic [N-1:0] wdata,
    input logic [N-1:0] en_q,
    input logic [N-1:0] st_q,
    input logic [N-1:0] typ_q,
    input logic         irq,
    input logic         fiq
);

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_EN) |=> (en_q == $past(wdata))); // R2

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (!irq && !fiq)); // R2

    AST_W1C_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_ST) |=>
        (($past(st_q) & ~$past(wdata) & $past(typ_q) & ~st_q) == '0)); // R3

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == REG_ST) |=>
        (($past(st_q) & $past(typ_q) & ~st_q) == '0)); // R4

    AST_TYP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_TYP) |=> (typ_q == $past(wdata))); // R8

endmodule

bind cic_slice cic_checker #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .en_q(en_w), .st_q(st_w), .typ_q(typ_w), .irq(irq), .fiq(fiq)
);

// File: tb/cic_top_tb.sv
`timescale 1ns/1ps
module cic_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  unit = 2'd0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [27:0] src_main = '0;
    logic [31:0] src_sub_a = '0;
    logic [31:0] src_sub_b = '0;
    logic        irq_o, fiq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] CASC = 32'hC000_0003;

    always #10 clk = ~clk;

    cic_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .unit(unit), .addr(addr),
        .wdata(wdata), .rdata(rdata), .src_main(src_main),
        .src_sub_a(src_sub_a), .src_sub_b(src_sub_b),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] u, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        unit = u; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] u, input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        unit = u; addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 0, v); check("R1 main enable", v, CASC);
        rd(0, 3, v); check("R1 main polarity", v, CASC);
        rd(0, 4, v); check("R1 main routing", v, 32'hC000_0000);
        rd(0, 2, v); check("R1 main type", v, 0);
        rd(0, 1, v); check("R1 main status", v, 0);
        rd(1, 0, v); check("R1 sub A enable", v, 0);
        rd(2, 1, v); check("R1 sub B status", v, 0);
        check("R1 outputs", {30'b0, irq_o, fiq_o}, 0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        wr(3, 0, 32'h0000_FFFF);
        rd(0, 0, v); check("R8 unit 3 write dropped", v, CASC);
        rd(1, 0, v); check("R8 unit 3 no sub A write", v, 0);
        rd(3, 0, v); check("R8 unit 3 reads zero", v, 0);
        rd(0, 6, v); check("R8 addr 6 reads zero", v, 0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(0, 2, 32'h20);
        wr(0, 3, CASC | 32'h20);
        wr(0, 1, 32'h20);
        wr(0, 0, CASC | 32'h20);
        rd(0, 1, v); check("R3 bit5 cleared", v & 32'h20, 0);
        @(negedge clk);
        src_main[3] = 1'b1;
        @(posedge clk); @(posedge clk); #5;
        check("R10 not after 2 edges", rdata & 32'h20, 0);
        @(posedge clk); #5;
        check("R10 set after 3 edges", rdata & 32'h20, 32'h20);
        @(negedge clk);
        check("R2 irq from bit5", {31'b0, irq_o}, 1);
        src_main[3] = 1'b0;
        settle();
        rd(0, 1, v); check("R4 rising latched", v & 32'h20, 32'h20);
        wr(0, 1, 32'h0);
        rd(0, 1, v); check("R3 zero write keeps", v & 32'h20, 32'h20);
        wr(0, 1, 32'h20);
        rd(0, 1, v); check("R3 one write clears", v & 32'h20, 0);
        check("R2 irq low after clear", {31'b0, irq_o}, 0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(0, 2, 32'h60);
        wr(0, 1, 32'h40);
        src_main[4] = 1'b1;
        settle();
        rd(0, 1, v); check("R4 rise ignored on falling cfg", v & 32'h40, 0);
        @(negedge clk); src_main[4] = 1'b0;
        settle();
        rd(0, 1, v); check("R4 falling latched", v & 32'h40, 32'h40);
        wr(0, 1, 32'h40);
    endtask

    task automatic t_level_high();
        logic [31:0] v;
        wr(0, 3, CASC | 32'hA0);
        settle();
        rd(0, 1, v); check("R5 high level idle", v & 32'h80, 0);
        src_main[5] = 1'b1;
        settle();
        rd(0, 1, v); check("R5 high level active", v & 32'h80, 32'h80);
        wr(0, 1, 32'h80);
        rd(0, 1, v); check("R5 clear ignored while active", v & 32'h80, 32'h80);
        @(negedge clk); src_main[5] = 1'b0;
        settle();
        rd(0, 1, v); check("R5 level released", v & 32'h80, 0);
    endtask

    task automatic t_level_low();
        logic [31:0] v;
        rd(0, 1, v); check("R5 low level active", v & 32'h100, 32'h100);
        src_main[6] = 1'b1;
        settle();
        rd(0, 1, v); check("R5 low level idle", v & 32'h100, 0);
        @(negedge clk); src_main[6] = 1'b0;
        settle();
        rd(0, 1, v); check("R5 low level again", v & 32'h100, 32'h100);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(0, 0, CASC);
        src_main[3] = 1'b1;
        settle();
        rd(0, 1, v); check("R2 masked still pends", v & 32'h20, 32'h20);
        check("R2 masked irq low", {31'b0, irq_o}, 0);
        rd(0, 5, v); check("R8 pending word masked", v & 32'h20, 0);
        wr(0, 0, CASC | 32'h20);
        rd(0, 5, v); check("R8 pending word enabled", v & 32'h20, 32'h20);
        check("R2 unmasked irq high", {31'b0, irq_o}, 1);
    endtask

    task automatic t_route();
        wr(0, 4, 32'hC000_0020);
        @(negedge clk);
        check("R6 fast route", {30'b0, irq_o, fiq_o}, 32'h1);
        wr(0, 4, 32'hC000_0000);
        check("R6 normal route", {30'b0, irq_o, fiq_o}, 32'h2);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(0, 0, CASC);
        check("R9 enable cleared drops irq", {31'b0, irq_o}, 0);
        wr(0, 1, 32'h20);
        rd(0, 1, v); check("R9 status cleared", v & 32'h20, 0);
        wr(0, 0, CASC | 32'h20);
        check("R9 stays low after re-enable", {31'b0, irq_o}, 0);
        @(negedge clk); src_main[3] = 1'b0;
    endtask

    task automatic t_cascade();
        logic [31:0] v;
        wr(1, 2, 32'h8);
        wr(1, 3, 32'h8);
        wr(1, 1, 32'h8);
        wr(1, 0, 32'h8);
        src_sub_a[3] = 1'b1;
        settle();
        rd(0, 1, v); check("R7 sub A normal to main 0", v & CASC, 32'h1);
        check("R7 irq via sub A", {30'b0, irq_o, fiq_o}, 32'h2);
        wr(1, 4, 32'h8);
        settle();
        rd(0, 1, v); check("R7 sub A fast to main 30", v & CASC, 32'h4000_0000);
        check("R7 fiq via sub A", {30'b0, irq_o, fiq_o}, 32'h1);
        wr(2, 3, 32'h200);
        wr(2, 0, 32'h200);
        src_sub_b[9] = 1'b1;
        settle();
        rd(0, 1, v); check("R7 sub B normal to main 1", v & CASC, 32'h4000_0002);
        check("R7 both outputs", {30'b0, irq_o, fiq_o}, 32'h3);
        wr(2, 4, 32'h200);
        settle();
        rd(0, 1, v); check("R7 sub B fast to main 31", v & CASC, 32'hC000_0000);
        @(negedge clk); src_sub_b[9] = 1'b0;
        settle();
        rd(0, 1, v); check("R5 cascade level follows", v & CASC, 32'h4000_0000);
        wr(1, 0, 32'h0);
        settle();
        check("R2 sub A masked clears fiq", {30'b0, irq_o, fiq_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        settle();
        t_decode();
        t_rise();
        t_fall();
        t_level_high();
        t_level_low();
        t_mask();
        t_route();
        t_ack();
        t_cascade();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule